// File: doc/BRIEF.md
# Processing Node Phase Sequencer

This controller steps one processing node through a batch loop that repeats without end: the node takes in a batch from the host, computes on it, and sends the results back. The controller does no data work itself. It raises a level enable to one of three external units at a time: the loader that copies host data into local memory, the compute engine, and the unloader that returns results. It then waits for a one-cycle done pulse from that unit before it moves on. A 2-bit select bus carries the current phase code to the multiplexers in front of the shared memories.

The node starts in the idle phase `PH_IDLE`. A start pulse from an external start-code detector causes the transition idle→load, to `PH_LOAD`. On the same edge the controller latches the operand constant that comes with the start code. After that the node cycles through three transitions: load→calc on `load_done`, calc→drain on `calc_done` and drain→load on `drain_done`. The phases involved are `PH_LOAD`, `PH_CALC` and `PH_DRAIN`. The only way back to idle is the synchronous reset.

Top module: `node_seq_ctrl`

## Requirements
- R1: After a synchronous active-high `rst`, `mem_sel` reads 0 (idle), `load_en`, `calc_en` and `drain_en` are all low and `coef_out` is zero.
- R2: In idle, a high `start_pulse` at a clock edge moves the phase to load (`mem_sel`=1). On that same edge `coef_out` takes the value of `start_const`.
- R3: In load, a high `load_done` at a clock edge moves the phase to calc (`mem_sel`=2).
- R4: In calc, a high `calc_done` at a clock edge moves the phase to drain (`mem_sel`=3).
- R5: In drain, a high `drain_done` at a clock edge moves the phase back to load (`mem_sel`=1), never to idle.
- R6: `load_en` is high exactly while `mem_sel`=1, `calc_en` exactly while `mem_sel`=2 and `drain_en` exactly while `mem_sel`=3. At most one enable is high at a time, and none is high in idle.
- R7: A done pulse that does not belong to the current phase has no effect on the phase. If several done inputs are high together, only the one that matches the current phase counts.
- R8: In the load, calc and drain phases, `start_pulse` has no effect: the phase does not change because of it and `coef_out` stays stable.
- R9: In idle without `start_pulse`, the phase stays idle, including when done pulses arrive.
- R10: A reset applied in any loop phase returns the controller to idle with all enables low and `coef_out` cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pulse | input | 1 | Start indication from the start-code detector |
| start_const | input | CONST_W | Operand constant that comes with the start code |
| load_done | input | 1 | Loader finished the batch |
| calc_done | input | 1 | Compute engine finished |
| drain_done | input | 1 | Unloader finished sending results |
| load_en | output | 1 | Enable for the host-to-memory loader |
| calc_en | output | 1 | Enable for the compute engine |
| drain_en | output | 1 | Enable for the memory-to-host unloader |
| mem_sel | output | 2 | Phase code for the memory multiplexer selects (0 idle, 1 load, 2 calc, 3 drain) |
| coef_out | output | CONST_W | Latched operand constant |

## Verification
The bench drives done pulses in the wrong phase and sets all three done inputs high at once. A decoder that listened to any done input would skip a phase or return to idle. Start pulses arrive while the loop is running, each with a new constant on `start_const`; a latch that was not gated on the idle phase would let `coef_out` drift away from its value. The bench checks that the end of the drain phase leads to load and not idle, and that a reset in the middle of the loop clears the latched constant.

// File: rtl/node_seq_pkg.sv
package node_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_CALC  = 2'd2,
        PH_DRAIN = 2'd3
    } phase_t;
endpackage

// File: rtl/node_seq_state.sv
module node_seq_state
    import node_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_pulse,
    input  logic   load_done,
    input  logic   calc_done,
    input  logic   drain_done,
    output phase_t phase
);
    phase_t phase_nx;

    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:  if (start_pulse) phase_nx = PH_LOAD;
            PH_LOAD:  if (load_done)   phase_nx = PH_CALC;
            PH_CALC:  if (calc_done)   phase_nx = PH_DRAIN;
            PH_DRAIN: if (drain_done)  phase_nx = PH_LOAD;
            default:                   phase_nx = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nx;
    end

    // R1 / R10: reset always lands in idle
    a_r10_reset_idle: assert property (@(posedge clk) rst |=> phase == PH_IDLE);
    a_r3_load_to_calc: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOAD && load_done) |=> phase == PH_CALC);
    a_r4_calc_to_drain: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_CALC && calc_done) |=> phase == PH_DRAIN);
    a_r5_drain_to_load: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DRAIN && drain_done) |=> phase == PH_LOAD);
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !start_pulse) |=> phase == PH_IDLE);
    a_r5_never_back_idle: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> phase != PH_IDLE);
endmodule

// File: rtl/node_seq_coef.sv
module node_seq_coef #(
    parameter int CONST_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [CONST_W-1:0] din,
    output logic [CONST_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (capture) q <= din;
    end
endmodule

// File: rtl/node_seq_outdec.sv
module node_seq_outdec
    import node_seq_pkg::*;
(
    input  phase_t     phase,
    output logic       load_en,
    output logic       calc_en,
    output logic       drain_en,
    output logic [1:0] mem_sel
);
    always_comb begin
        load_en  = 1'b0;
        calc_en  = 1'b0;
        drain_en = 1'b0;
        unique case (phase)
            PH_IDLE:  ;
            PH_LOAD:  load_en  = 1'b1;
            PH_CALC:  calc_en  = 1'b1;
            PH_DRAIN: drain_en = 1'b1;
            default:  ;
        endcase
        mem_sel = phase;
    end

    // R6: enables are mutually exclusive
    always_comb begin
        a_r6_one_enable: assert ($onehot0({load_en, calc_en, drain_en}));
    end
endmodule

// File: rtl/node_seq_ctrl.sv
module node_seq_ctrl
    import node_seq_pkg::*;
#(
    parameter int CONST_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_pulse,
    input  logic [CONST_W-1:0] start_const,
    input  logic               load_done,
    input  logic               calc_done,
    input  logic               drain_done,
    output logic               load_en,
    output logic               calc_en,
    output logic               drain_en,
    output logic [1:0]         mem_sel,
    output logic [CONST_W-1:0] coef_out
);
    phase_t phase;
    logic   take_const;

    node_seq_state u_state (
        .clk         (clk),
        .rst         (rst),
        .start_pulse (start_pulse),
        .load_done   (load_done),
        .calc_done   (calc_done),
        .drain_done  (drain_done),
        .phase       (phase)
    );

    assign take_const = (phase == PH_IDLE) && start_pulse;

    node_seq_coef #(.CONST_W(CONST_W)) u_coef (
        .clk     (clk),
        .rst     (rst),
        .capture (take_const),
        .din     (start_const),
        .q       (coef_out)
    );

    node_seq_outdec u_dec (
        .phase    (phase),
        .load_en  (load_en),
        .calc_en  (calc_en),
        .drain_en (drain_en),
        .mem_sel  (mem_sel)
    );

    a_r2_const_taken: assert property (@(posedge clk) disable iff (rst)
        (mem_sel == 2'd0 && start_pulse) |=> (coef_out == $past(start_const) && mem_sel == 2'd1));
    a_r8_const_stable: assert property (@(posedge clk) disable iff (rst)
        (mem_sel != 2'd0) |=> $stable(coef_out));
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (coef_out == '0 && !load_en && !calc_en && !drain_en));
    a_r6_sel_matches_enable: assert property (@(posedge clk) disable iff (rst)
        (load_en == (mem_sel == 2'd1)) && (calc_en == (mem_sel == 2'd2)) && (drain_en == (mem_sel == 2'd3)));
endmodule

// File: tb/node_seq_ctrl_tb.sv
`timescale 1ns/1ps
module node_seq_ctrl_tb;
    localparam int CW = 32;
    localparam int NV = 16;
    // vector: [5] start, [4] load_done, [3] calc_done, [2] drain_done, [1:0] expected phase after edge
    localparam logic [5:0] VEC [NV] = '{
        6'b0000_00, // R9 idle stays
        6'b0111_00, // R9 dones in idle ignored
        6'b1000_01, // R2 start
        6'b0000_01, // load holds
        6'b0010_01, // R7 calc_done in load
        6'b0001_01, // R7 drain_done in load
        6'b1000_01, // R8 start in load
        6'b0100_10, // R3
        6'b1100_10, // R7/R8 load_done+start in calc
        6'b0001_10, // R7
        6'b0010_11, // R4
        6'b0110_11, // R7
        6'b0001_01, // R5 back to load
        6'b0111_10, // R7 all dones in load
        6'b0010_11, // R4
        6'b0001_01  // R5
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          start_pulse, load_done, calc_done, drain_done;
    logic [CW-1:0] start_const;
    logic          load_en, calc_en, drain_en;
    logic [1:0]    mem_sel;
    logic [CW-1:0] coef_out;
    int            n_chk = 0;
    int            n_err = 0;
    bit            finished = 1'b0;

    always #2.5 clk = ~clk;

    node_seq_ctrl #(.CONST_W(CW)) u_dut (
        .clk(clk), .rst(rst), .start_pulse(start_pulse), .start_const(start_const),
        .load_done(load_done), .calc_done(calc_done), .drain_done(drain_done),
        .load_en(load_en), .calc_en(calc_en), .drain_en(drain_en),
        .mem_sel(mem_sel), .coef_out(coef_out)
    );

    task automatic chk(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_phase(input string req, input logic [1:0] ph, input logic [CW-1:0] cf);
        chk(req, {30'd0, mem_sel}, {30'd0, ph});
        chk({req, " R6 enables"}, {29'd0, load_en, calc_en, drain_en},
            {29'd0, ph == 2'd1, ph == 2'd2, ph == 2'd3});
        chk({req, " const"}, coef_out, cf);
    endtask

    task automatic step(input logic s, input logic l, input logic c, input logic d, input logic [CW-1:0] k);
        start_pulse = s; load_done = l; calc_done = c; drain_done = d; start_const = k;
        @(negedge clk);
        start_pulse = 0; load_done = 0; calc_done = 0; drain_done = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #100000;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [CW-1:0] held;
        rst = 1; start_pulse = 0; load_done = 0; calc_done = 0; drain_done = 0;
        start_const = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        chk_phase("R1 reset", 2'd0, '0);

        held = '0;
        for (int i = 0; i < NV; i++) begin
            logic [CW-1:0] k;
            k = 32'hC0DE_0000 + 32'(i * 17);
            if (VEC[i][5] && mem_sel == 2'd0) held = k;
            step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], k);
            chk_phase($sformatf("R2-R9 vector %0d", i), VEC[i][1:0], held);
        end

        // R10: reset from calc clears everything
        step(0, 1, 0, 0, '0);
        chk_phase("R3 before reset", 2'd2, held);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk_phase("R10 reset mid-loop", 2'd0, '0);

        // R2: a fresh start takes a new constant
        step(1, 0, 0, 0, 32'h1234_5678);
        chk_phase("R2 restart", 2'd1, 32'h1234_5678);
        step(0, 1, 0, 0, 32'hFFFF_FFFF);
        step(0, 0, 1, 0, 32'hFFFF_FFFF);
        chk_phase("R4 after restart", 2'd3, 32'h1234_5678);
        step(1, 0, 0, 0, 32'hAAAA_AAAA);
        chk_phase("R8 start in drain", 2'd3, 32'h1234_5678);
        step(0, 0, 0, 1, '0);
        chk_phase("R5 drain to load", 2'd1, 32'h1234_5678);

        // R10: reset from drain
        step(0, 1, 0, 0, '0);
        step(0, 0, 1, 0, '0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk_phase("R10 reset from drain", 2'd0, '0);
        step(0, 0, 0, 1, '0);
        chk_phase("R9 done after reset", 2'd0, '0);

        finish_run();
    end
endmodule